// File: doc/BRIEF.md
# ECC Error Capture Register Block

This block sits next to a DRAM controller's ECC checker and keeps a record of memory faults for software. The checker reports correctable and uncorrectable errors as single-cycle pulses. Each pulse comes with the failing cache-line address (physical address bits 32:7, because errors are logged at 128-byte grain), the channel number and the 8-bit ECC syndrome. Three other event pulses also feed the block: a refresh timeout, a locked access that targets non-DRAM memory, and a thermal sensor trip. All of them set sticky flags in a status register.

Software reaches five registers over a small register bus. The bus has a 3-bit register select, a write strobe and 16-bit write data, and the read data is combinational. Status flags are cleared by writing ones to them. The command register decides which events also drive the system-error output, which is a single-cycle pulse. The captured address is split over two registers. One holds address bits 31:7 together with the channel. A separate extension register holds address bit 32. Only one set of error details is kept. An uncorrectable error takes precedence over a correctable one that is already logged. Any later error is dropped until software clears the flags.

Top module: `ecc_err_log`

## Requirements
- R1: The status register (select 0) is 16 bits, zero-extended on the 32-bit read bus. Its flags are: bit 0 correctable ECC error, bit 1 uncorrectable ECC error, bit 8 refresh timeout, bit 9 lock to non-DRAM memory, bit 11 thermal event. All other bits always read 0, so only the mask 0x0B03 can ever be set.
- R2: Writing the status register clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R3: An event pulse sets its flag in the cycle after the pulse. The flag stays set until it is cleared by a write.
- R4: The command register (select 1) holds enables at bit positions 0, 1, 8, 9 and 11, which match the status flags. Writes to other bit positions are dropped, and those bits read 0.
- R5: The serr output pulses high for exactly one cycle, in the same cycle that a status flag first reads 1. It pulses only when that flag went from 0 to 1 and its command enable was set. An event whose flag is already set raises no pulse.
- R6: When an uncorrectable error arrives and no uncorrectable error is logged, three registers are loaded, replacing any correctable-error details:
  - The pointer register (select 2) gets address bits 31:7 in bits 31:7, zeros in bits 6:1, and the channel in bit 0.
  - The extension register (select 3) gets address bit 32 in bit 0, with bits 7:1 reading 0.
  - The syndrome register (select 4) gets the syndrome.
  The correctable flag stays set. A second uncorrectable error leaves all three registers unchanged.
- R7: A correctable error loads the pointer, extension and syndrome registers only when neither ECC flag is set. Otherwise it leaves those registers unchanged.
- R8: When a clear write and a new event for the same flag fall in the same cycle, the flag stays set, and serr does not pulse for it.
- R9: When correctable and uncorrectable pulses arrive together with nothing logged, both flags are set and the uncorrectable error's details are captured.
- R10: After reset every register reads 0 and serr is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_valid | input | 1 | Correctable ECC error pulse |
| ue_valid | input | 1 | Uncorrectable ECC error pulse |
| err_line | input | 26 | Failing physical address bits 32:7 |
| err_chan | input | 1 | Failing channel |
| err_syn | input | 8 | ECC syndrome of the failing access |
| refresh_to | input | 1 | Refresh timeout event pulse |
| lock_nondram | input | 1 | Locked access to non-DRAM memory event pulse |
| thermal | input | 1 | Thermal sensor event pulse |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| serr | output | 1 | System-error pulse for enabled events |

## Verification
Each event pulse passes through one register stage. Its status flag, the captured details and any serr pulse all appear in the cycle after the pulse, and serr drops again one cycle later. Register writes take effect at the next edge. Read data follows the register select combinationally within the same cycle. The bench drives every input on a falling edge, holds a pulse for one full cycle, and samples status and serr at the following falling edge. It reads registers a moment after setting the select. It checks serr a second time one cycle later to confirm the pulse is a single cycle long.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_CMD    = 3'd1,
        SEL_PTR    = 3'd2,
        SEL_XPTR   = 3'd3,
        SEL_SYN    = 3'd4
    } reg_sel_e;

    localparam int FLAG_W = 16;

    localparam int BIT_CE    = 0;
    localparam int BIT_UE    = 1;
    localparam int BIT_RFTO  = 8;
    localparam int BIT_LOCK  = 9;
    localparam int BIT_THERM = 11;

    localparam logic [FLAG_W-1:0] EVT_MASK =
        FLAG_W'((1 << BIT_CE) | (1 << BIT_UE) | (1 << BIT_RFTO) |
                (1 << BIT_LOCK) | (1 << BIT_THERM));

endpackage

// File: rtl/ecc_log_status.sv
module ecc_log_status
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] evt_set,
    input  logic [FLAG_W-1:0] clr_mask,
    input  logic [FLAG_W-1:0] cmd,
    output logic [FLAG_W-1:0] status,
    output logic              serr
);

    typedef struct packed {
        logic [FLAG_W-1:0] sts;
        logic              serr;
    } st_t;

    st_t st_d, st_q;
    logic [FLAG_W-1:0] rise;

    always_comb begin
        st_d     = st_q;
        // a new event overrides a clear of the same bit
        st_d.sts = ((st_q.sts & ~clr_mask) | evt_set) & EVT_MASK;
        rise     = evt_set & ~st_q.sts & EVT_MASK;
        st_d.serr = |(rise & cmd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q.sts;
    assign serr   = st_q.serr;

endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
    parameter int PADDR_W   = 33,
    parameter int GRAIN_LSB = 7,
    parameter int SYN_W     = 8,
    parameter int PTR_W     = 32,
    localparam int LINE_W   = PADDR_W - GRAIN_LSB,
    localparam int LOW_W    = PTR_W - GRAIN_LSB,
    localparam int XADDR_W  = PADDR_W - PTR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_valid,
    input  logic               ue_valid,
    input  logic [LINE_W-1:0]  err_line,
    input  logic               err_chan,
    input  logic [SYN_W-1:0]   err_syn,
    input  logic               ce_held,
    input  logic               ue_held,
    output logic [PTR_W-1:0]   ptr,
    output logic [XADDR_W-1:0] xaddr,
    output logic [SYN_W-1:0]   syn
);

    typedef struct packed {
        logic [PTR_W-1:0]   ptr;
        logic [XADDR_W-1:0] xaddr;
        logic [SYN_W-1:0]   syn;
    } cap_t;

    cap_t cap_d, cap_q;
    logic take_ue, take_ce, take;

    always_comb begin
        take_ue = ue_valid & ~ue_held;
        take_ce = ce_valid & ~ue_valid & ~ce_held & ~ue_held;
        take    = take_ue | take_ce;
        cap_d   = cap_q;
        if (take) begin
            cap_d.ptr   = {err_line[LOW_W-1:0], {(GRAIN_LSB-1){1'b0}}, err_chan};
            cap_d.xaddr = err_line[LINE_W-1:LOW_W];
            cap_d.syn   = err_syn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign ptr   = cap_q.ptr;
    assign xaddr = cap_q.xaddr;
    assign syn   = cap_q.syn;

endmodule

// File: rtl/ecc_log_regs.sv
module ecc_log_regs
    import ecc_log_pkg::*;
#(
    parameter int PTR_W   = 32,
    parameter int XADDR_W = 1,
    parameter int XREG_W  = 8,
    parameter int SYN_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  reg_sel_e           reg_sel,
    input  logic               reg_wr,
    input  logic [FLAG_W-1:0]  reg_wdata,
    input  logic [FLAG_W-1:0]  status,
    input  logic [PTR_W-1:0]   ptr,
    input  logic [XADDR_W-1:0] xaddr,
    input  logic [SYN_W-1:0]   syn,
    output logic [PTR_W-1:0]   reg_rdata,
    output logic [FLAG_W-1:0]  cmd,
    output logic [FLAG_W-1:0]  clr_mask
);

    typedef struct packed {
        logic [FLAG_W-1:0] cmd;
    } rg_t;

    rg_t rg_d, rg_q;
    logic [XREG_W-1:0] xreg;

    generate
        if (XREG_W > XADDR_W) begin : g_xpad
            assign xreg = {{(XREG_W-XADDR_W){1'b0}}, xaddr};
        end else begin : g_xfull
            assign xreg = xaddr[XREG_W-1:0];
        end
    endgenerate

    always_comb begin
        rg_d = rg_q;
        if (reg_wr && reg_sel == SEL_CMD) begin
            rg_d.cmd = reg_wdata & EVT_MASK;
        end
        clr_mask = (reg_wr && reg_sel == SEL_STATUS) ? reg_wdata : '0;
        unique case (reg_sel)
            SEL_STATUS: reg_rdata = {{(PTR_W-FLAG_W){1'b0}}, status};
            SEL_CMD:    reg_rdata = {{(PTR_W-FLAG_W){1'b0}}, rg_q.cmd};
            SEL_PTR:    reg_rdata = ptr;
            SEL_XPTR:   reg_rdata = {{(PTR_W-XREG_W){1'b0}}, xreg};
            SEL_SYN:    reg_rdata = {{(PTR_W-SYN_W){1'b0}}, syn};
            default:    reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign cmd = rg_q.cmd;

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int PADDR_W   = 33,
    parameter int GRAIN_LSB = 7,
    parameter int SYN_W     = 8,
    parameter int PTR_W     = 32,
    parameter int XREG_W    = 8,
    localparam int LINE_W   = PADDR_W - GRAIN_LSB,
    localparam int XADDR_W  = PADDR_W - PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_valid,
    input  logic              ue_valid,
    input  logic [LINE_W-1:0] err_line,
    input  logic              err_chan,
    input  logic [SYN_W-1:0]  err_syn,
    input  logic              refresh_to,
    input  logic              lock_nondram,
    input  logic              thermal,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [FLAG_W-1:0] reg_wdata,
    output logic [PTR_W-1:0]  reg_rdata,
    output logic              serr
);

    logic [FLAG_W-1:0]  evt_set;
    logic [FLAG_W-1:0]  status_q;
    logic [FLAG_W-1:0]  cmd_q;
    logic [FLAG_W-1:0]  clr_mask;
    logic [FLAG_W-1:0]  kept;
    logic [PTR_W-1:0]   ptr_q;
    logic [XADDR_W-1:0] xaddr_q;
    logic [SYN_W-1:0]   syn_q;

    always_comb begin
        evt_set            = '0;
        evt_set[BIT_CE]    = ce_valid;
        evt_set[BIT_UE]    = ue_valid;
        evt_set[BIT_RFTO]  = refresh_to;
        evt_set[BIT_LOCK]  = lock_nondram;
        evt_set[BIT_THERM] = thermal;
        kept               = status_q & ~clr_mask;
    end

    ecc_log_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (evt_set),
        .clr_mask (clr_mask),
        .cmd      (cmd_q),
        .status   (status_q),
        .serr     (serr)
    );

    ecc_log_capture #(
        .PADDR_W   (PADDR_W),
        .GRAIN_LSB (GRAIN_LSB),
        .SYN_W     (SYN_W),
        .PTR_W     (PTR_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_valid (ce_valid),
        .ue_valid (ue_valid),
        .err_line (err_line),
        .err_chan (err_chan),
        .err_syn  (err_syn),
        .ce_held  (kept[BIT_CE]),
        .ue_held  (kept[BIT_UE]),
        .ptr      (ptr_q),
        .xaddr    (xaddr_q),
        .syn      (syn_q)
    );

    ecc_log_regs #(
        .PTR_W   (PTR_W),
        .XADDR_W (XADDR_W),
        .XREG_W  (XREG_W),
        .SYN_W   (SYN_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel_e'(reg_addr)),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .status    (status_q),
        .ptr       (ptr_q),
        .xaddr     (xaddr_q),
        .syn       (syn_q),
        .reg_rdata (reg_rdata),
        .cmd       (cmd_q),
        .clr_mask  (clr_mask)
    );

endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
    import ecc_log_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ce_valid,
    input logic              ue_valid,
    input logic              refresh_to,
    input logic              lock_nondram,
    input logic              thermal,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              serr,
    input logic [FLAG_W-1:0] status_q,
    input logic [FLAG_W-1:0] cmd_q,
    input logic [FLAG_W-1:0] clr_mask,
    input logic [31:0]       ptr_q
);

    logic [FLAG_W-1:0] evt_vec;
    always_comb begin
        evt_vec            = '0;
        evt_vec[BIT_CE]    = ce_valid;
        evt_vec[BIT_UE]    = ue_valid;
        evt_vec[BIT_RFTO]  = refresh_to;
        evt_vec[BIT_LOCK]  = lock_nondram;
        evt_vec[BIT_THERM] = thermal;
    end

    // R1: reserved status bits never read as 1
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd0) |-> ((reg_rdata & ~32'h0000_0B03) == 32'd0));

    // R2: bits cleared without a coincident event read 0 afterwards
    a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((status_q & $past(clr_mask & ~evt_vec)) == '0));

    // R3: an uncorrectable pulse sets its flag one cycle later
    a_r3_ue_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        ue_valid |=> status_q[BIT_UE]);

    // R3: a flag with no clear pending stays set
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[BIT_CE] && !clr_mask[BIT_CE]) |=> status_q[BIT_CE]);

    // R5: serr follows an enabled event
    a_r5_serr_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        serr |-> ($past(cmd_q & evt_vec) != '0));

    // R5: serr coincides with a flag that just rose
    a_r5_serr_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        serr |-> ((status_q & ~$past(status_q)) != '0));

    // R6: logged uncorrectable details are held until the flag is cleared
    a_r6_ue_details_held: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[BIT_UE] && !clr_mask[BIT_UE]) |=> $stable(ptr_q));

endmodule

bind ecc_err_log ecc_err_log_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_valid     (ce_valid),
    .ue_valid     (ue_valid),
    .refresh_to   (refresh_to),
    .lock_nondram (lock_nondram),
    .thermal      (thermal),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .serr         (serr),
    .status_q     (status_q),
    .cmd_q        (cmd_q),
    .clr_mask     (clr_mask),
    .ptr_q        (ptr_q)
);

// File: tb/ecc_err_log_tb.sv
`timescale 1ns/1ps
module ecc_err_log_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_valid = 1'b0, ue_valid = 1'b0;
    logic [25:0] err_line = '0;
    logic        err_chan = 1'b0;
    logic [7:0]  err_syn = '0;
    logic        refresh_to = 1'b0, lock_nondram = 1'b0, thermal = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        serr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ecc_err_log u_dut (
        .clk(clk), .rst_n(rst_n), .ce_valid(ce_valid), .ue_valid(ue_valid),
        .err_line(err_line), .err_chan(err_chan), .err_syn(err_syn),
        .refresh_to(refresh_to), .lock_nondram(lock_nondram), .thermal(thermal),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .serr(serr)
    );

    typedef struct packed {
        logic        clr;
        logic        ce;
        logic        ue;
        logic [32:0] addr;
        logic        chan;
        logic [7:0]  syn;
        logic [15:0] sts;
        logic [31:0] ptr;
        logic [7:0]  xp;
        logic [7:0]  sy;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        // R7: first correctable error captured
        '{1'b1, 1'b1, 1'b0, 33'h1_2345_6789, 1'b1, 8'hA5, 16'h0001, 32'h2345_6781, 8'h01, 8'hA5},
        // R7: second correctable error ignored
        '{1'b0, 1'b1, 1'b0, 33'h0_0000_1000, 1'b0, 8'h11, 16'h0001, 32'h2345_6781, 8'h01, 8'hA5},
        // R6: uncorrectable overwrites correctable details
        '{1'b0, 1'b0, 1'b1, 33'h0_ABCD_EF7F, 1'b0, 8'h3C, 16'h0003, 32'hABCD_EF00, 8'h00, 8'h3C},
        // R6: second uncorrectable ignored
        '{1'b0, 1'b0, 1'b1, 33'h1_0000_0080, 1'b1, 8'h77, 16'h0003, 32'hABCD_EF00, 8'h00, 8'h3C},
        // R9: both at once, uncorrectable details win
        '{1'b1, 1'b1, 1'b1, 33'h0_0000_0FFF, 1'b1, 8'h5A, 16'h0003, 32'h0000_0F81, 8'h00, 8'h5A},
        // R7: fresh correctable after clear, high address
        '{1'b1, 1'b1, 1'b0, 33'h1_FFFF_FFFF, 1'b0, 8'hFF, 16'h0001, 32'hFFFF_FF80, 8'h01, 8'hFF}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    // drive one pulse, return serr as seen in the cycle after the pulse
    task automatic ev(input logic ce, input logic ue, input logic [32:0] addr, input logic ch,
                      input logic [7:0] sy, input logic [2:0] misc, output logic s);
        @(negedge clk);
        ce_valid = ce; ue_valid = ue;
        err_line = addr[32:7]; err_chan = ch; err_syn = sy;
        refresh_to = misc[0]; lock_nondram = misc[1]; thermal = misc[2];
        @(negedge clk);
        ce_valid = 1'b0; ue_valid = 1'b0;
        refresh_to = 1'b0; lock_nondram = 1'b0; thermal = 1'b0;
        s = serr;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk(d == 32'd0, "R10 reset register", d, 32'd0);
        end
        chk(serr == 1'b0, "R10 reset serr", {31'd0, serr}, 32'd0);

        // R4: command writes keep only enable positions
        wr(3'd1, 16'hFFFF);
        rd(3'd1, d);
        chk(d == 32'h0000_0B03, "R4 command mask", d, 32'h0000_0B03);
        wr(3'd1, 16'h0000);

        // table of ECC capture scenarios
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].clr) wr(3'd0, 16'h0B03);
            ev(VECS[i].ce, VECS[i].ue, VECS[i].addr, VECS[i].chan, VECS[i].syn, 3'b000, s);
            rd(3'd0, d);
            chk(d == {16'd0, VECS[i].sts}, "R1 R3 vector status", d, {16'd0, VECS[i].sts});
            rd(3'd2, d);
            chk(d == VECS[i].ptr, "R6 R7 vector pointer", d, VECS[i].ptr);
            rd(3'd3, d);
            chk(d == {24'd0, VECS[i].xp}, "R6 R7 vector extension", d, {24'd0, VECS[i].xp});
            rd(3'd4, d);
            chk(d == {24'd0, VECS[i].sy}, "R6 R7 vector syndrome", d, {24'd0, VECS[i].sy});
        end

        // R5: enabled event pulses serr for one cycle
        wr(3'd0, 16'h0B03);
        wr(3'd1, 16'h0200);
        ev(1'b0, 1'b0, 33'd0, 1'b0, 8'd0, 3'b111, s);
        chk(s == 1'b1, "R5 serr on enabled event", {31'd0, s}, 32'd1);
        @(negedge clk);
        chk(serr == 1'b0, "R5 serr single cycle", {31'd0, serr}, 32'd0);
        rd(3'd0, d);
        chk(d == 32'h0000_0B00, "R1 R3 other events status", d, 32'h0000_0B00);

        // R5: flag already set gives no pulse
        ev(1'b0, 1'b0, 33'd0, 1'b0, 8'd0, 3'b010, s);
        chk(s == 1'b0, "R5 no serr when flag already set", {31'd0, s}, 32'd0);

        // R2: write of ones clears, zeros keep
        wr(3'd0, 16'h0100);
        rd(3'd0, d);
        chk(d == 32'h0000_0A00, "R2 partial clear", d, 32'h0000_0A00);
        wr(3'd0, 16'h0000);
        rd(3'd0, d);
        chk(d == 32'h0000_0A00, "R2 zero write keeps flags", d, 32'h0000_0A00);

        // R8: clear and new event in the same cycle
        wr(3'd1, 16'h0800);
        @(negedge clk);
        reg_addr = 3'd0; reg_wdata = 16'h0800; reg_wr = 1'b1; thermal = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; thermal = 1'b0;
        chk(serr == 1'b0, "R8 no serr on clear collision", {31'd0, serr}, 32'd0);
        rd(3'd0, d);
        chk(d == 32'h0000_0A00, "R8 event wins over clear", d, 32'h0000_0A00);

        // R5: disabled event sets flag without serr
        wr(3'd0, 16'h0B03);
        wr(3'd1, 16'h0000);
        ev(1'b0, 1'b0, 33'd0, 1'b0, 8'd0, 3'b100, s);
        chk(s == 1'b0, "R5 no serr when disabled", {31'd0, s}, 32'd0);
        rd(3'd0, d);
        chk(d == 32'h0000_0800, "R3 thermal flag", d, 32'h0000_0800);

        // R5: enabled uncorrectable error raises serr
        wr(3'd1, 16'h0002);
        ev(1'b0, 1'b1, 33'h0_0000_0200, 1'b0, 8'h01, 3'b000, s);
        chk(s == 1'b1, "R5 serr on uncorrectable", {31'd0, s}, 32'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule